// File: doc/BRIEF.md
# Parallel Three-Plane Cell Grid with Staged Results

The block is a rectangular grid of identical processing cells (32 rows by 32 columns at full size). Each cell keeps four 16-bit word registers, organised into planes: A, B and C are operand planes and T is a scratch plane. A single command applies one element-wise operation to every cell at once. The command runs in one of two directions. In the forward direction A and B are combined into C. In the reverse direction C and B are combined back into A.

Every result first lands in T and is then copied to its destination on the next cycle. A sequencer walks through three states: IDLE, COMPUTE and COMMIT. Transition IDLE→COMPUTE happens on an accepted command. COMPUTE→COMMIT always follows one cycle later, and COMMIT→IDLE follows one cycle after that.

A row-wide load port writes one row of one plane per cycle. A row-wide readback port returns one row of one plane a cycle after the request. Both ports are locked out while an operation is in flight.

Top module: `cell_grid_engine`

## Requirements
- R1: After reset every word of all four planes reads as zero, `busy` is low and `rd_valid` is low.
- R2: A command on `op_start` is accepted only in IDLE and only with `op_code` 0 to 4. `busy` is then high for exactly the two cycles after the accepting edge. A start while busy, or with `op_code` 5, 6 or 7, is ignored.
- R3: With `op_dir`=0, every cell writes `A op B` into C. A and B are left unchanged.
- R4: With `op_dir`=1, every cell writes `C op B` into A. B and C are left unchanged.
- R5: Opcode encoding:
  - 0 is addition modulo 2^16.
  - 1 is subtraction of B from the other operand, modulo 2^16.
  - 2 is bitwise AND.
  - 3 is bitwise OR.
  - 4 is bitwise XOR.
- R6: After an operation completes, the T plane holds the same result that was committed to the destination plane.
- R7: `wr_en` writes `wr_data` into row `wr_row` of plane `wr_plane`.
  - Plane codes: 0=A, 1=B, 2=C, 3=T.
  - Column j takes bits [16j+15:16j].
  - A write is refused while `busy` is high, and also in the same cycle that a command is accepted.
- R8: `rd_en` while not busy returns row `rd_row` of plane `rd_plane` on `rd_data`, with `rd_valid` high, on the following cycle. The row is packed the same way as for a write. A read request while busy is ignored and gives `rd_valid` low.
- R9: Direction and opcode are captured at acceptance. Changes to `op_dir` or `op_code` while busy do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Request an element-wise operation |
| op_dir | input | 1 | 0: A,B→C; 1: C,B→A |
| op_code | input | 3 | Element operation select |
| busy | output | 1 | Operation in COMPUTE or COMMIT |
| wr_en | input | 1 | Row load request |
| wr_plane | input | 2 | Plane for the load |
| wr_row | input | RAW | Row for the load |
| wr_data | input | COLS*WIDTH | Packed row of words to load |
| rd_en | input | 1 | Row readback request |
| rd_plane | input | 2 | Plane to read |
| rd_row | input | RAW | Row to read |
| rd_valid | output | 1 | rd_data holds a requested row |
| rd_data | output | COLS*WIDTH | Packed row of words read |

## Verification
The hardest situations to reach are collisions between the port traffic and a running operation. Examples are a second start one cycle after the first, a load or readback landing in COMPUTE or COMMIT, and a load in the very cycle a start is accepted. Opcode and direction changes made mid-operation are also hard to reach.

The stimulus reaches these by issuing a command and then, on the following edges, deliberately driving conflicting starts, illegal opcodes, writes and reads. A behavioural model compares `busy`, `rd_valid` and `rd_data` on every clock, and full-plane readbacks afterwards expose any stray update. Operand rows are seeded with wrap-around values (0xFFFF+1, 0−1, 0x8000+0x8000) so that the modulo behaviour is reached in both directions.

// File: rtl/cgrid_pkg.sv
package cgrid_pkg;

    typedef enum logic [1:0] {
        PL_A = 2'd0,
        PL_B = 2'd1,
        PL_C = 2'd2,
        PL_T = 2'd3
    } plane_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_COMMIT  = 2'd2
    } seq_state_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= OP_LAST;
    endfunction

endpackage

// File: rtl/cgrid_alu.sv
module cgrid_alu #(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] r
);
    import cgrid_pkg::*;

    always_comb begin
        case (op)
            OP_ADD:  r = x + y;
            OP_SUB:  r = x - y;
            OP_AND:  r = x & y;
            OP_OR:   r = x | y;
            OP_XOR:  r = x ^ y;
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/cgrid_seq.sv
module cgrid_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dir_in,
    input  logic [2:0] op_in,
    output logic       busy,
    output logic       accept,
    output logic       calc_en,
    output logic       commit_en,
    output logic       dir_q,
    output logic [2:0] op_q
);
    import cgrid_pkg::*;

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            op_q  <= 3'd0;
        end else if (accept) begin
            dir_q <= dir_in;
            op_q  <= op_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        calc_en   = 1'b0;
        commit_en = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept    = start && op_legal(op_in);
            ST_COMPUTE: begin busy = 1'b1; calc_en = 1'b1; end
            ST_COMMIT:  begin busy = 1'b1; commit_en = 1'b1; end
            default:    busy      = 1'b0;
        endcase
    end

    AST_ACCEPT_TO_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ST_COMPUTE)); // R2
    AST_COMPUTE_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPUTE) |=> (state_q == ST_COMMIT)); // R2
    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE)); // R2
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(op_q) && $stable(dir_q))); // R9
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, calc_en, commit_en})); // R2

endmodule

// File: rtl/cgrid_cell.sv
module cgrid_cell #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [1:0]       ld_plane,
    input  logic [WIDTH-1:0] ld_word,
    input  logic             calc_en,
    input  logic             commit_en,
    input  logic             dir,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic [WIDTH-1:0] c_q,
    output logic [WIDTH-1:0] t_q
);
    import cgrid_pkg::*;

    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] res;

    assign src = dir ? c_q : a_q;

    cgrid_alu #(.WIDTH(WIDTH)) u_alu (
        .op (op),
        .x  (src),
        .y  (b_q),
        .r  (res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
            t_q <= '0;
        end else begin
            if (ld_en) begin
                unique case (plane_e'(ld_plane))
                    PL_A: a_q <= ld_word;
                    PL_B: b_q <= ld_word;
                    PL_C: c_q <= ld_word;
                    PL_T: t_q <= ld_word;
                    default: ;
                endcase
            end
            if (calc_en) begin
                t_q <= res;
            end
            if (commit_en) begin
                if (dir) a_q <= t_q;
                else     c_q <= t_q;
            end
        end
    end

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !(calc_en || commit_en)); // R7
    AST_B_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en || commit_en) |=> $stable(b_q)); // R3
    AST_FWD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !dir) |=> ((c_q == $past(t_q)) && $stable(a_q))); // R3
    AST_REV_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && dir) |=> ((a_q == $past(t_q)) && $stable(c_q))); // R4
    AST_T_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> $stable(t_q)); // R6

endmodule

// File: rtl/cell_grid_engine.sv
module cell_grid_engine #(
    parameter int ROWS  = 32,
    parameter int COLS  = 32,
    parameter int WIDTH = 16,
    localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ROWW = COLS * WIDTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_start,
    input  logic            op_dir,
    input  logic [2:0]      op_code,
    output logic            busy,
    input  logic            wr_en,
    input  logic [1:0]      wr_plane,
    input  logic [RAW-1:0]  wr_row,
    input  logic [ROWW-1:0] wr_data,
    input  logic            rd_en,
    input  logic [1:0]      rd_plane,
    input  logic [RAW-1:0]  rd_row,
    output logic            rd_valid,
    output logic [ROWW-1:0] rd_data
);
    import cgrid_pkg::*;

    localparam logic [RAW:0] ROW_LIMIT = ROWS[RAW:0];

    logic       accept;
    logic       calc_en;
    logic       commit_en;
    logic       dir_q;
    logic [2:0] op_q;
    logic       wr_go;
    logic       rd_go;

    logic [ROWW-1:0] rows_a [ROWS];
    logic [ROWW-1:0] rows_b [ROWS];
    logic [ROWW-1:0] rows_c [ROWS];
    logic [ROWW-1:0] rows_t [ROWS];
    logic [ROWW-1:0] rd_sel;

    cgrid_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .dir_in    (op_dir),
        .op_in     (op_code),
        .busy      (busy),
        .accept    (accept),
        .calc_en   (calc_en),
        .commit_en (commit_en),
        .dir_q     (dir_q),
        .op_q      (op_q)
    );

    assign wr_go = wr_en && !busy && !accept;
    assign rd_go = rd_en && !busy;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic            row_hit;
        logic [ROWW-1:0] wa, wb, wc, wt;

        assign row_hit = wr_go && (wr_row == RAW'(r));

        for (genvar c = 0; c < COLS; c++) begin : g_col
            cgrid_cell #(.WIDTH(WIDTH)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_en     (row_hit),
                .ld_plane  (wr_plane),
                .ld_word   (wr_data[c*WIDTH +: WIDTH]),
                .calc_en   (calc_en),
                .commit_en (commit_en),
                .dir       (dir_q),
                .op        (op_q),
                .a_q       (wa[c*WIDTH +: WIDTH]),
                .b_q       (wb[c*WIDTH +: WIDTH]),
                .c_q       (wc[c*WIDTH +: WIDTH]),
                .t_q       (wt[c*WIDTH +: WIDTH])
            );
        end

        assign rows_a[r] = wa;
        assign rows_b[r] = wb;
        assign rows_c[r] = wc;
        assign rows_t[r] = wt;
    end

    always_comb begin
        rd_sel = '0;
        if ({1'b0, rd_row} < ROW_LIMIT) begin
            unique case (plane_e'(rd_plane))
                PL_A: rd_sel = rows_a[rd_row];
                PL_B: rd_sel = rows_b[rd_row];
                PL_C: rd_sel = rows_c[rd_row];
                PL_T: rd_sel = rows_t[rd_row];
                default: rd_sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= rd_sel;
        end
    end

    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R2
    AST_NO_RDV_AFTER_BUSY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> !rd_valid); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data)); // R8

endmodule

// File: tb/cell_grid_engine_test.sv
`timescale 1ns/1ps
module cell_grid_engine_test;
    localparam int BR  = 4;
    localparam int BC  = 3;
    localparam int W   = 16;
    localparam int RAW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_start = 1'b0;
    logic            op_dir = 1'b0;
    logic [2:0]      op_code = 3'd0;
    logic            busy;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_plane = 2'd0;
    logic [RAW-1:0]  wr_row = '0;
    logic [BC*W-1:0] wr_data = '0;
    logic            rd_en = 1'b0;
    logic [1:0]      rd_plane = 2'd0;
    logic [RAW-1:0]  rd_row = '0;
    logic            rd_valid;
    logic [BC*W-1:0] rd_data;

    cell_grid_engine #(.ROWS(BR), .COLS(BC), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_dir(op_dir),
        .op_code(op_code), .busy(busy), .wr_en(wr_en), .wr_plane(wr_plane),
        .wr_row(wr_row), .wr_data(wr_data), .rd_en(rd_en), .rd_plane(rd_plane),
        .rd_row(rd_row), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    // behavioural reference
    int    mdl [4][BR][BC];
    int    m_phase = 0;      // 0 idle, 1 compute, 2 commit
    int    m_dir = 0, m_op = 0;
    int    m_rdv = 0;
    int    m_rd [BC];
    int    tests = 0, fails = 0;
    int    cycles = 0;
    bit    checking = 0;
    string cur_req = "R1";
    int    pat [BC];

    function automatic int calc(int op, int x, int y);
        case (op)
            0: return (x + y) & 16'hFFFF;
            1: return (x - y) & 16'hFFFF;
            2: return x & y;
            3: return x | y;
            default: return x ^ y;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mdl[p, r, c]) mdl[p][r][c] = 0;
            m_phase = 0; m_rdv = 0;
        end else begin
            int  was_busy;
            bit  acc;
            was_busy = (m_phase != 0);
            acc = !was_busy && op_start && (op_code <= 3'd4);
            m_rdv = (rd_en && !was_busy) ? 1 : 0;
            if (m_rdv == 1)
                for (int c = 0; c < BC; c++) m_rd[c] = mdl[rd_plane][rd_row][c];
            if (wr_en && !was_busy && !acc)
                for (int c = 0; c < BC; c++) mdl[wr_plane][wr_row][c] = int'(wr_data[c*W +: W]);
            if (m_phase == 1) begin
                for (int r = 0; r < BR; r++)
                    for (int c = 0; c < BC; c++)
                        mdl[3][r][c] = calc(m_op, mdl[m_dir ? 2 : 0][r][c], mdl[1][r][c]);
                m_phase = 2;
            end else if (m_phase == 2) begin
                for (int r = 0; r < BR; r++)
                    for (int c = 0; c < BC; c++)
                        mdl[m_dir ? 0 : 2][r][c] = mdl[3][r][c];
                m_phase = 0;
            end else if (acc) begin
                m_phase = 1; m_dir = op_dir; m_op = int'(op_code);
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            tests++;
            if (busy !== (m_phase != 0)) begin
                fails++;
                $display("FAIL %s busy got %0d expected %0d", cur_req, busy, m_phase != 0);
            end
            tests++;
            if (rd_valid !== (m_rdv == 1)) begin
                fails++;
                $display("FAIL %s rd_valid got %0d expected %0d", cur_req, rd_valid, m_rdv);
            end
            if (m_rdv == 1) begin
                for (int c = 0; c < BC; c++) begin
                    tests++;
                    if (int'(rd_data[c*W +: W]) != m_rd[c]) begin
                        fails++;
                        $display("FAIL %s rd_data col %0d got %h expected %h",
                                 cur_req, c, rd_data[c*W +: W], m_rd[c][15:0]);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic t_write(int pl, int row);
        wr_en = 1'b1; wr_plane = 2'(pl); wr_row = RAW'(row);
        for (int c = 0; c < BC; c++) wr_data[c*W +: W] = pat[c][15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_read(int pl, int row);
        rd_en = 1'b1; rd_plane = 2'(pl); rd_row = RAW'(row);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_op(int dir, int op);
        op_start = 1'b1; op_dir = dir[0]; op_code = 3'(op);
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic t_idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic dump_all();
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < BR; r++) t_read(p, r);
        t_idle(1);
    endtask

    initial begin
        t_idle(2);
        @(negedge clk);
        rst_n = 1'b1;
        checking = 1;
        // R1: reset contents
        cur_req = "R1";
        dump_all();

        // R7: loads, including wrap-around seeds
        cur_req = "R7";
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < BR; r++) begin
                for (int c = 0; c < BC; c++) pat[c] = int'($urandom() & 16'hFFFF);
                t_write(p, r);
            end
        pat[0] = 16'hFFFF; pat[1] = 0;       pat[2] = 16'h8000; t_write(0, 0);
        pat[0] = 1;        pat[1] = 1;       pat[2] = 16'h8000; t_write(1, 0);
        pat[0] = 16'h1234; pat[1] = 16'h55AA; pat[2] = 7;       t_write(3, 2);
        // R8: readback of everything loaded
        cur_req = "R8";
        dump_all();

        // R3 / R5 / R6: forward direction, every opcode
        for (int op = 0; op < 5; op++) begin
            cur_req = (op == 0) ? "R3" : "R5";
            t_op(0, op);
            t_idle(2);
            cur_req = "R6";
            dump_all();
        end

        // R4: reverse direction, every opcode
        for (int op = 0; op < 5; op++) begin
            pat[0] = 0; pat[1] = 5; pat[2] = 16'hF0F0; t_write(2, 1);
            cur_req = "R4";
            t_op(1, op);
            t_idle(2);
            dump_all();
        end

        // R2: second start while busy, illegal opcodes
        cur_req = "R2";
        t_op(0, 0);
        t_op(1, 1);
        t_op(1, 4);
        t_idle(2);
        t_op(0, 5);
        t_op(1, 7);
        t_op(0, 6);
        dump_all();

        // R9: command inputs changing mid-operation
        cur_req = "R9";
        t_op(1, 1);
        op_dir = 1'b0; op_code = 3'd3;
        t_idle(2);
        dump_all();

        // R7: writes while busy and in the accepting cycle
        cur_req = "R7";
        t_op(0, 2);
        pat[0] = 16'hDEAD; pat[1] = 16'hBEEF; pat[2] = 16'hCAFE;
        t_write(1, 3);
        t_write(0, 3);
        op_start = 1'b1; op_dir = 1'b0; op_code = 3'd4;
        wr_en = 1'b1; wr_plane = 2'd1; wr_row = 2'd1;
        for (int c = 0; c < BC; c++) wr_data[c*W +: W] = 16'h0F0F;
        @(negedge clk);
        op_start = 1'b0; wr_en = 1'b0;
        t_idle(2);
        dump_all();

        // R8: reads while busy
        cur_req = "R8";
        t_op(1, 0);
        t_read(2, 0);
        t_read(0, 1);
        t_read(1, 2);
        t_idle(2);

        checking = 0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule